// File: doc/BRIEF.md
# Codec Power Mode Controller

This block supervises the digital timing inputs of a voice codec and decides which of three power states the codec occupies: operating, power-saving or power-down. It samples the serial bit clock, the transmit frame sync and an active-low power-down pin with a free-running system clock. It reports the chosen state on a two-bit status output. From that state it derives six enable lines: the transmit path, the receive path, the PCM output driver, the reference generator, the PLL and the receive driver amplifiers.

A low power-down pin always wins and forces power-down. If either the bit clock or the frame sync stops toggling, the block drops into power-saving by itself, whether the stalled line is stuck high or stuck low. In power-saving the reference, PLL and receive drivers stay enabled. Leaving power-saving is deliberately slow. The bit clock must keep toggling across three whole frame periods, and the return to operating then happens on a frame-sync rising edge, so the codec always restarts on a frame boundary.

All pins are plain control and status lines. There is no data stream and no handshake. The bit clock and frame sync are treated as asynchronous levels and are never used as clocks.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset the block reports power-saving (pwr_mode = 2'b01) with the power-saving enable pattern, before any qualification has happened.
- R2: A low on pwr_dn_n gives pwr_mode = 2'b10 with all six enables low within SYNC_STAGES+1 system clocks. This takes priority over every other condition, including a stalled bit clock.
- R3: When pwr_dn_n returns high, the block enters power-saving (2'b01), never operating directly. It stays there while the clocks are not yet qualified.
- R4: In operating mode, if bit_clk shows no edge for BCLK_TIMEOUT system clocks (held at 1 or at 0), the block enters power-saving. It does not do so earlier than that.
- R5: In operating mode, if frame_sync shows no rising edge for FS_TIMEOUT system clocks, the block enters power-saving. It does not do so earlier than that.
- R6: Enable pattern. In operating mode all six enables are 1. In power-saving, ref_en, pll_en and rxdrv_en are 1 while tx_en, rx_en and pcm_oe are 0. In power-down all six are 0.
- R7: Counting from the first frame-sync rising edge seen in power-saving with bit_clk toggling, the block stays at 2'b01 through the third rising edge. It switches to 2'b00 on the fourth, which closes three full periods.
- R8: If bit_clk stalls while exit qualification is in progress, the count of qualified periods restarts from zero.
- R9: pwr_mode uses only the codes 2'b00 (operating), 2'b01 (power-saving) and 2'b10 (power-down), never 2'b11.
- R10: While in operating mode, frame periods that vary from frame to frame within the tolerated 6 kHz to 10 kHz band keep the block in operating mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Serial bit clock, sampled as an asynchronous level |
| frame_sync | input | 1 | Transmit frame sync, sampled as an asynchronous level |
| pwr_dn_n | input | 1 | Active-low hard power-down request |
| pwr_mode | output | 2 | Power state: 00 operating, 01 power-saving, 10 power-down |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| pcm_oe | output | 1 | PCM output driver enable (driver is high impedance when low) |
| ref_en | output | 1 | Reference generator enable |
| pll_en | output | 1 | PLL enable |
| rxdrv_en | output | 1 | Receive driver amplifier enable |

## Verification
The assertions check several rules on every cycle:
- power-down follows a low synchronized request, and power-down is left only for power-saving;
- a dead bit-clock or frame-sync timer forces operating mode out;
- operating mode is never entered outside a frame-sync rising edge;
- the state code stays legal;
- the PCM driver is never on without the transmit path and reference.

Only the bench scenarios can show the counted behaviours. These are the exact edge on which qualification ends, the restart of the count after a mid-qualification stall, the upper and lower timeout windows, and tolerance of frame periods that vary within the band.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PM_OPER = 2'b00,
    PM_SAVE = 2'b01,
    PM_DOWN = 2'b10
  } pm_mode_t;

  typedef struct packed {
    logic ref_en;
    logic pll_en;
    logic rxdrv_en;
    logic tx_en;
    logic rx_en;
    logic pcm_oe;
  } pm_en_t;
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/cpc_edge_det.sv
module cpc_edge_det #(
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic edge_p
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end
  if (RISE_ONLY) begin : g_rise
    assign edge_p = level & ~prev;
  end else begin : g_any
    assign edge_p = level ^ prev;
  end
endmodule

// File: rtl/cpc_idle_timer.sv
module cpc_idle_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic alive
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= CMAX;
    else if (kick)         cnt <= '0;
    else if (cnt != CMAX)  cnt <= cnt + 1'b1;
  end
  assign alive = (cnt != CMAX);

  // R4/R5: an observed edge revives the line on the next cycle
  a_r4_kick_revives: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> alive);
  // R4/R5: a dead line stays dead until an edge is seen
  a_r5_dead_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!alive && !kick) |=> !alive);
endmodule

// File: rtl/cpc_mode_fsm.sv
module cpc_mode_fsm
  import cpc_pkg::*;
#(
  parameter int EXIT_PERIODS = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pdn_ok,
  input  logic     bclk_alive,
  input  logic     fs_alive,
  input  logic     fs_rise,
  output pm_mode_t mode
);
  localparam int QW = $clog2(EXIT_PERIODS + 1);
  localparam logic [QW-1:0] QDONE = QW'(EXIT_PERIODS);

  logic [QW-1:0] qual;
  logic          clocks_ok;
  assign clocks_ok = bclk_alive && fs_alive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= PM_SAVE;
      qual <= '0;
    end else if (!pdn_ok) begin
      mode <= PM_DOWN;
      qual <= '0;
    end else begin
      unique case (mode)
        PM_DOWN: begin
          mode <= PM_SAVE;
          qual <= '0;
        end
        PM_OPER: begin
          if (!clocks_ok) mode <= PM_SAVE;
          qual <= '0;
        end
        PM_SAVE: begin
          if (!bclk_alive || (!fs_alive && !fs_rise)) begin
            qual <= '0;
          end else if (fs_rise) begin
            if (qual == QDONE) begin
              mode <= PM_OPER;
              qual <= '0;
            end else begin
              qual <= qual + 1'b1;
            end
          end
        end
        default: begin
          mode <= PM_SAVE;
          qual <= '0;
        end
      endcase
    end
  end

  a_r2_pdn_forces_down: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_ok |=> mode == PM_DOWN);
  a_r3_wake_to_save: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_DOWN && pdn_ok) |=> mode == PM_SAVE);
  a_r4_bclk_dead_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OPER && pdn_ok && !bclk_alive) |=> mode == PM_SAVE);
  a_r5_fs_dead_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OPER && pdn_ok && !fs_alive) |=> mode == PM_SAVE);
  a_r7_exit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SAVE && !fs_rise) |=> mode != PM_OPER);
  a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
endmodule

// File: rtl/cpc_enable_dec.sv
module cpc_enable_dec
  import cpc_pkg::*;
(
  input  pm_mode_t mode,
  output pm_en_t   en
);
  always_comb begin
    en = '0;
    unique case (mode)
      PM_OPER: en = '1;
      PM_SAVE: begin
        en.ref_en   = 1'b1;
        en.pll_en   = 1'b1;
        en.rxdrv_en = 1'b1;
      end
      default: en = '0;
    endcase
  end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BCLK_TIMEOUT = 64,
  parameter int FS_TIMEOUT   = 70000,
  parameter int EXIT_PERIODS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_clk,
  input  logic       frame_sync,
  input  logic       pwr_dn_n,
  output logic [1:0] pwr_mode,
  output logic       tx_en,
  output logic       rx_en,
  output logic       pcm_oe,
  output logic       ref_en,
  output logic       pll_en,
  output logic       rxdrv_en
);
  localparam int NIN = 3;

  logic [NIN-1:0] raw_in, sync_in;
  logic bclk_edge, fs_rise, bclk_alive, fs_alive;
  pm_mode_t mode;
  pm_en_t   en;

  assign raw_in = {pwr_dn_n, frame_sync, bit_clk};

  cpc_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_in));

  cpc_edge_det #(.RISE_ONLY(1'b0)) u_bclk_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_in[0]), .edge_p(bclk_edge));
  cpc_edge_det #(.RISE_ONLY(1'b1)) u_fs_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_in[1]), .edge_p(fs_rise));

  cpc_idle_timer #(.LIMIT(BCLK_TIMEOUT)) u_bclk_tmr (
    .clk(clk), .rst_n(rst_n), .kick(bclk_edge), .alive(bclk_alive));
  cpc_idle_timer #(.LIMIT(FS_TIMEOUT)) u_fs_tmr (
    .clk(clk), .rst_n(rst_n), .kick(fs_rise), .alive(fs_alive));

  cpc_mode_fsm #(.EXIT_PERIODS(EXIT_PERIODS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pdn_ok(sync_in[2]), .bclk_alive(bclk_alive),
    .fs_alive(fs_alive), .fs_rise(fs_rise), .mode(mode));

  cpc_enable_dec u_dec (.mode(mode), .en(en));

  assign pwr_mode = mode;
  assign tx_en    = en.tx_en;
  assign rx_en    = en.rx_en;
  assign pcm_oe   = en.pcm_oe;
  assign ref_en   = en.ref_en;
  assign pll_en   = en.pll_en;
  assign rxdrv_en = en.rxdrv_en;

  // R6: PCM driver never on without the transmit path, reference and PLL
  a_r6_pcm_needs_path: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> (tx_en && ref_en && pll_en));
endmodule

// File: tb/codec_pwr_ctrl_test.sv
module codec_pwr_ctrl_test;
  localparam int BT    = 64;
  localparam int FT    = 720;
  localparam int BHALF = 4;
  localparam int FS_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk, frame_sync;
  logic pwr_dn_n = 1'b1;
  logic [1:0] pwr_mode;
  logic tx_en, rx_en, pcm_oe, ref_en, pll_en, rxdrv_en;

  logic bclk_run = 1'b1, bclk_hold = 1'b0;
  logic fs_run = 1'b0, fs_hold = 1'b0, fs_jitter = 1'b0;
  int   fs_period = 256;
  int   fs_rises = 0;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  codec_pwr_ctrl #(.SYNC_STAGES(2), .BCLK_TIMEOUT(BT), .FS_TIMEOUT(FT),
                   .EXIT_PERIODS(3)) uut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
    .pwr_dn_n(pwr_dn_n), .pwr_mode(pwr_mode), .tx_en(tx_en), .rx_en(rx_en),
    .pcm_oe(pcm_oe), .ref_en(ref_en), .pll_en(pll_en), .rxdrv_en(rxdrv_en));

  // expected {ref,pll,rxdrv,tx,rx,pcm} for a mode code (R6)
  function automatic logic [5:0] exp_en(input logic [1:0] m);
    case (m)
      2'b00:   return 6'b111111;
      2'b01:   return 6'b111000;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [1:0] m);
    logic [5:0] act;
    act = {ref_en, pll_en, rxdrv_en, tx_en, rx_en, pcm_oe};
    checks++;
    if (pwr_mode !== m || act !== exp_en(m)) begin
      errors++;
      $display("FAIL %s: mode=%b en=%b expected mode=%b en=%b",
               req, pwr_mode, act, m, exp_en(m));
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rises(input int target);
    while (fs_rises < target) @(negedge clk);
  endtask

  // bit clock generator
  initial begin
    int c = 0;
    bit_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (bclk_run) begin
        c++;
        if (c >= BHALF) begin c = 0; bit_clk = ~bit_clk; end
      end else begin
        c = 0;
        bit_clk = bclk_hold;
      end
    end
  end

  // frame sync generator
  initial begin
    int c = 0;
    frame_sync = 1'b0;
    forever begin
      @(negedge clk);
      if (fs_run) begin
        if (c == 0) begin frame_sync = 1'b1; fs_rises++; end
        else if (c == FS_W) frame_sync = 1'b0;
        c++;
        if (c >= fs_period) begin
          c = 0;
          if (fs_jitter) fs_period = 205 + int'($urandom_range(135));
        end
      end else begin
        c = 0;
        frame_sync = fs_hold;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h00C0DEC5));
    cyc(10);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset state", 2'b01);

    // R7: exact exit edge
    cyc(100);
    n = fs_rises;
    fs_run = 1'b1;
    wait_rises(n + 3); cyc(10);
    chk("R7 still saving after third rise", 2'b01);
    wait_rises(n + 4);
    chk("R7 saving at fourth rise", 2'b01);
    cyc(6);
    chk("R7 operating after fourth rise (R6 pattern)", 2'b00);

    // R10: frame periods varying inside the band
    fs_jitter = 1'b1;
    for (int i = 0; i < 20; i++) begin
      n = fs_rises;
      wait_rises(n + 1); cyc(6);
      chk("R10 varying frame period", 2'b00);
    end
    fs_jitter = 1'b0;
    fs_period = 256;

    // R4: bit clock stuck high
    while (bit_clk !== 1'b1) @(negedge clk);
    bclk_hold = 1'b1; bclk_run = 1'b0;
    cyc(40);
    chk("R4 not before timeout (stuck high)", 2'b00);
    cyc(40);
    chk("R4 stuck high gives saving", 2'b01);

    // R8: stall during qualification restarts the count
    n = fs_rises;
    wait_rises(n + 1); cyc(10);
    bclk_run = 1'b1;
    wait_rises(n + 3); cyc(10);
    while (bit_clk !== 1'b0) @(negedge clk);
    bclk_hold = 1'b0; bclk_run = 1'b0;
    cyc(100);
    chk("R8 R4 stuck low stays saving", 2'b01);
    n = fs_rises;
    wait_rises(n + 1); cyc(10);
    bclk_run = 1'b1;
    wait_rises(n + 4); cyc(10);
    chk("R8 count restarted after stall", 2'b01);
    wait_rises(n + 5); cyc(6);
    chk("R8 exit after fresh qualification", 2'b00);

    // R5: frame sync stuck high
    n = fs_rises;
    wait_rises(n + 1); cyc(3);
    fs_hold = 1'b1; fs_run = 1'b0;
    cyc(500);
    chk("R5 not before timeout", 2'b00);
    cyc(260);
    chk("R5 frame sync stuck gives saving", 2'b01);

    // back to operating
    fs_hold = 1'b0; cyc(20);
    n = fs_rises;
    fs_run = 1'b1;
    wait_rises(n + 5); cyc(6);
    chk("R7 requalified", 2'b00);

    // R2 / R3: hard power-down and its priority
    pwr_dn_n = 1'b0; cyc(5);
    chk("R2 power-down", 2'b10);
    bclk_hold = bit_clk; bclk_run = 1'b0;
    cyc(100);
    chk("R2 priority over stalled bit clock", 2'b10);
    pwr_dn_n = 1'b1; cyc(5);
    chk("R3 release goes to saving", 2'b01);
    cyc(300);
    chk("R3 stays saving while unqualified", 2'b01);
    bclk_run = 1'b1;
    n = fs_rises;
    wait_rises(n + 5); cyc(6);
    chk("R7 requalified after wake", 2'b00);

    // random power-down pulses
    for (int i = 0; i < 4; i++) begin
      int len;
      len = 1 + int'($urandom_range(19));
      pwr_dn_n = 1'b0; cyc(len);
      pwr_dn_n = 1'b1; cyc(6);
      chk("R3 R9 saving after random pulse", 2'b01);
      n = fs_rises;
      wait_rises(n + 5); cyc(6);
      chk("R7 R9 operating after requalification", 2'b00);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule